// File: doc/BRIEF.md
# Indexed Peripheral Clock Settings Register

This block is a single 32-bit control register window through which the clock settings of up to 64 peripherals are reached. Every peripheral owns one stored entry: an ordinary clock enable, an ordinary clock divisor, a generated clock enable, a generated clock source select and a generated clock divisor. An identifier field in every written word picks the entry that the window points at. The block only holds the settings. The clock generation that uses them is outside it.

A command bit decides what a write does. A write with the command bit at 0 only moves the window to the named entry, so that the next read returns that entry. A write with the command bit at 1 also moves the window, and it stores the written fields into the named entry. Software changes one entry by reading, modifying and writing it. It writes the identifier alone, reads the entry back, then writes the changed word with the command bit set.

The bus side is a request channel and a response channel, each with valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A read request returns its data on the response channel. That response stays valid and stable until `rsp_ready` is high. While a response is waiting, `req_ready` is held low, so at most one read is outstanding. A write produces no response.

Top module: `periph_clk_ctl`

## Requirements
- R1: After reset every entry reads as zero (clocks disabled, source 0, both divisors 0) and the window points at identifier 0, so a first read returns 0x00000000.
- R2: A write with bit 12 at 0 changes no entry. The next read returns the unchanged entry of the identifier written in bits [5:0].
- R3: A write with bit 12 at 1 stores into the entry named by bits [5:0] the generated source from bits [10:8], the ordinary divisor from bits [17:16], the generated divisor from bits [27:20], the ordinary enable from bit 28 and the generated enable from bit 29. A later read returns those fields at the same positions.
- R4: Read data carries the selected identifier in bits [5:0] and 0 in bit 12 and in bits 31:30, 19:18, 15:13, 11 and 7:6, whatever was written there.
- R5: A commit to identifier 0 or 1 stores the ordinary enable and divisor but leaves that entry's generated enable, source and divisor at zero. From identifier 2 upward all fields are stored.
- R6: A commit changes only the entry it names. All other entries keep their values.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid with stable data, and `req_ready` stays low.
- R8: A read accepted on a clock edge presents `rsp_valid` with its data from that edge onward. The data reflects every write accepted on earlier edges.
- R9: A commit write also selects its identifier, so a read that directly follows it returns that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word (identifier, command bit, fields) |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data word |

## Verification
The bench builds the block with its default parameters. That gives all 64 entries, and the generated fields are held at zero below identifier 2. These values bring the lowest and highest identifiers (0 and 63) within reach, along with both sides of the 1/2 boundary where the generated fields start to be stored. They also let a commit to one entry be checked against a neighbouring entry that must keep its contents. Stalling the response channel for several cycles exercises the back-pressure rules.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int WORD_W   = 32;
  localparam int IDREG_W  = 6;
  localparam int CMD_POS  = 12;
  localparam int SRC_LSB  = 8;
  localparam int PDIV_LSB = 16;
  localparam int GDIV_LSB = 20;
  localparam int PEN_POS  = 28;
  localparam int GEN_POS  = 29;

  typedef struct packed {
    logic       gen_en;
    logic       per_en;
    logic [7:0] gen_div;
    logic [1:0] per_div;
    logic [2:0] gen_src;
  } pcr_entry_t;

  function automatic logic [WORD_W-1:0] pcr_pack(pcr_entry_t e, logic [IDREG_W-1:0] id);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDREG_W-1:0]          = id;
    w[SRC_LSB+2:SRC_LSB]    = e.gen_src;
    w[PDIV_LSB+1:PDIV_LSB]  = e.per_div;
    w[GDIV_LSB+7:GDIV_LSB]  = e.gen_div;
    w[PEN_POS]              = e.per_en;
    w[GEN_POS]              = e.gen_en;
    return w;
  endfunction
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
#(
  parameter int FIRST_GEN_ID = 2
) (
  input  logic [WORD_W-1:0]  wdata,
  output logic [IDREG_W-1:0] id,
  output logic               cmd,
  output pcr_entry_t         ent
);
  localparam logic [IDREG_W:0] FIRST_GEN_V = (IDREG_W+1)'(FIRST_GEN_ID);

  logic gen_allowed;
  logic unused_bits;

  assign id          = wdata[IDREG_W-1:0];
  assign cmd         = wdata[CMD_POS];
  assign gen_allowed = {1'b0, id} >= FIRST_GEN_V;
  assign unused_bits = ^{wdata[31:30], wdata[19:18], wdata[15:13], wdata[11], wdata[7:6]};

  always_comb begin
    ent         = '0;
    ent.per_en  = wdata[PEN_POS];
    ent.per_div = wdata[PDIV_LSB+1:PDIV_LSB];
    if (gen_allowed) begin
      ent.gen_en  = wdata[GEN_POS];
      ent.gen_src = wdata[SRC_LSB+2:SRC_LSB];
      ent.gen_div = wdata[GDIV_LSB+7:GDIV_LSB];
    end
  end
endmodule

// File: rtl/pcr_table.sv
module pcr_table
  import pcr_pkg::*;
#(
  parameter int NUM_ENT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDREG_W-1:0] wr_idx,
  input  pcr_entry_t         wr_ent,
  input  logic [IDREG_W-1:0] rd_idx,
  output pcr_entry_t         rd_ent
);
  localparam int              IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDREG_W:0] NUM_ENT_V = (IDREG_W+1)'(NUM_ENT);

  pcr_entry_t ent_q [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDREG_W'(g))) begin
        ent_q[g] <= wr_ent;
      end
    end
  end

  always_comb begin
    rd_ent = '0;
    if ({1'b0, rd_idx} < NUM_ENT_V) begin
      rd_ent = ent_q[rd_idx[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/periph_clk_ctl.sv
module periph_clk_ctl
  import pcr_pkg::*;
#(
  parameter int NUM_ENT      = 64,
  parameter int FIRST_GEN_ID = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata
);
  logic [IDREG_W-1:0] sel_q;
  logic [IDREG_W-1:0] dec_id;
  logic               dec_cmd;
  pcr_entry_t         dec_ent;
  pcr_entry_t         rd_ent;
  logic               wr_fire;
  logic               rd_fire;

  assign req_ready = !rsp_valid;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  pcr_decode #(.FIRST_GEN_ID(FIRST_GEN_ID)) u_decode (
    .wdata (req_wdata),
    .id    (dec_id),
    .cmd   (dec_cmd),
    .ent   (dec_ent)
  );

  pcr_table #(.NUM_ENT(NUM_ENT)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_fire && dec_cmd),
    .wr_idx (dec_id),
    .wr_ent (dec_ent),
    .rd_idx (sel_q),
    .rd_ent (rd_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_fire) begin
      sel_q <= dec_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= pcr_pack(rd_ent, sel_q);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
  parameter int FIRST_GEN_ID = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata
);
  localparam logic [31:0] RSV_MASK = 32'hC00CF8C0 | 32'h0000_1000 | 32'h0000_0800;
  localparam logic [6:0]  FIRST_GEN_V = 7'(FIRST_GEN_ID);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R7

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & RSV_MASK) == 32'h0)); // R4

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid); // R8

  AST_LOW_ID_GEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && ({1'b0, rsp_rdata[5:0]} < FIRST_GEN_V)
      |-> (rsp_rdata[29] == 1'b0) && (rsp_rdata[27:20] == 8'h0) && (rsp_rdata[10:8] == 3'h0)); // R5
endmodule

bind periph_clk_ctl pcr_checker #(.FIRST_GEN_ID(FIRST_GEN_ID)) u_pcr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_periph_clk_ctl.sv
module test_periph_clk_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  periph_clk_ctl i_periph_clk_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] mk(logic [5:0] id, logic [2:0] src, logic [1:0] pdiv,
                                     logic [7:0] gdiv, logic pe, logic ge, logic cmd);
    return {2'b00, ge, pe, gdiv, 2'b00, pdiv, 3'b000, cmd, 1'b0, src, 2'b00, id};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [31:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(d);
    check("R1 first read after reset", d, 32'h0);
    bus_write(mk(6'd63, 3'd0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    bus_read(d);
    check("R1 entry 63 at reset", d, mk(6'd63, 3'd0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_commit;
    logic [31:0] d;
    // junk in reserved bits 31,30,19,14,7
    bus_write(mk(6'd5, 3'd5, 2'd2, 8'hA7, 1'b1, 1'b1, 1'b1) | 32'hC008_4080);
    bus_read(d);
    check("R3/R9 commit id 5 readback", d, mk(6'd5, 3'd5, 2'd2, 8'hA7, 1'b1, 1'b1, 1'b0));
    check("R4 reserved and command bits zero", d & 32'hC00C_F8C0 | (d & 32'h1000), 32'h0);
  endtask

  task automatic t_select_only;
    logic [31:0] d;
    bus_write(mk(6'd5, 3'd1, 2'd1, 8'h11, 1'b0, 1'b0, 1'b0));
    bus_read(d);
    check("R2 select write leaves entry 5", d, mk(6'd5, 3'd5, 2'd2, 8'hA7, 1'b1, 1'b1, 1'b0));
  endtask

  task automatic t_independent;
    logic [31:0] d;
    bus_write(mk(6'd6, 3'd3, 2'd3, 8'h3C, 1'b0, 1'b1, 1'b1));
    bus_write(mk(6'd5, 3'd0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    bus_read(d);
    check("R6 entry 5 untouched by commit to 6", d, mk(6'd5, 3'd5, 2'd2, 8'hA7, 1'b1, 1'b1, 1'b0));
    bus_write(mk(6'd6, 3'd0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    bus_read(d);
    check("R3 entry 6 readback", d, mk(6'd6, 3'd3, 2'd3, 8'h3C, 1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_low_ids;
    logic [31:0] d;
    bus_write(mk(6'd1, 3'd7, 2'd3, 8'hFF, 1'b1, 1'b1, 1'b1));
    bus_read(d);
    check("R5 id 1 generated fields stay zero", d, mk(6'd1, 3'd0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0));
    bus_write(mk(6'd0, 3'd6, 2'd1, 8'h80, 1'b1, 1'b1, 1'b1));
    bus_read(d);
    check("R5 id 0 generated fields stay zero", d, mk(6'd0, 3'd0, 2'd1, 8'h00, 1'b1, 1'b0, 1'b0));
    bus_write(mk(6'd2, 3'd7, 2'd3, 8'hFF, 1'b1, 1'b1, 1'b1));
    bus_read(d);
    check("R5 id 2 stores all fields", d, mk(6'd2, 3'd7, 2'd3, 8'hFF, 1'b1, 1'b1, 1'b0));
  endtask

  task automatic t_top_id;
    logic [31:0] d;
    bus_write(mk(6'd63, 3'd2, 2'd1, 8'h5A, 1'b1, 1'b0, 1'b1));
    bus_read(d);
    check("R3 id 63 readback", d, mk(6'd63, 3'd2, 2'd1, 8'h5A, 1'b1, 1'b0, 1'b0));
    bus_write(mk(6'd2, 3'd0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    bus_read(d);
    check("R6 id 2 untouched by commit to 63", d, mk(6'd2, 3'd7, 2'd3, 8'hFF, 1'b1, 1'b1, 1'b0));
  endtask

  task automatic t_backpressure;
    logic [31:0] first;
    bus_write(mk(6'd6, 3'd0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first = rsp_rdata;
    check("R8 data under stall", first, mk(6'd6, 3'd3, 2'd3, 8'h3C, 1'b0, 1'b1, 1'b0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 rsp_valid held", {31'b0, rsp_valid}, 32'd1);
      check("R7 rsp data stable", rsp_rdata, first);
      check("R7 req_ready low", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R7 response released", {31'b0, rsp_valid}, 32'd0);
    check("R7 req_ready back", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 no response after reset", {31'b0, rsp_valid}, 32'd0);
    t_reset();
    t_commit();
    t_select_only();
    t_independent();
    t_low_ids();
    t_top_id();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule